// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a 32-bit saturating arithmetic unit for a processor datapath. The arithmetic path is combinational. It clamps signed and unsigned sums and differences at the edges of their range, and it doubles a signed value with clamping. It also limits a value to a programmable signed or unsigned bit width, either as one 32-bit word or as two independent 16-bit halves. One add operation keeps the wrapped sum and only reports that a signed overflow occurred.

A single sticky flag records that a clamp happened since the flag was last cleared. The flag collects events from every operation kind. Only an explicit clear strobe lowers it. The result is present in the same cycle as the operands, and the flag takes the event on the next clock edge. Instruction decode and the register file belong to the surrounding pipeline.

Top module: `sat_alu`

## Requirements
- R1: Code 0 (signed add, clamping) returns the wrapped sum of `opnd_a` and `opnd_b`. When both operands have the same sign and the sum's sign differs from `opnd_a`, it instead returns 0x7FFFFFFF if `opnd_a` is non-negative, or 0x80000000 if it is negative, and this counts as a saturation event.
- R2: Code 1 (signed subtract, clamping) returns `opnd_a - opnd_b`. When the operands differ in sign and the difference's sign differs from `opnd_a`, it instead returns 0x7FFFFFFF if `opnd_a` is non-negative, or 0x80000000 if it is negative, and this is a saturation event.
- R3: Code 2 (checked add) always returns the wrapped sum. It raises a saturation event under the signed overflow condition of R1.
- R4: Code 3 (signed doubling of `opnd_a`) returns 0x7FFFFFFF with an event when the signed input is at least 0x40000000. It returns 0x80000000 with an event when the input is at most 0xC0000000 (signed). Otherwise it returns the input shifted left by one.
- R5: Code 4 (unsigned add) returns 0xFFFFFFFF with an event when the sum carries out of bit 31. Otherwise it returns the sum.
- R6: Code 5 (unsigned subtract) returns 0 with an event when `opnd_b` is greater than `opnd_a` as unsigned values. Otherwise it returns the difference.
- R7: Code 6 (signed width limit, s = `sat_width`) takes `opnd_a` arithmetically shifted right by s. If that value is above 0, the result is 2^s-1. If it is below -1, the result is the bitwise inverse of 2^s-1. Both of these are events. Otherwise `opnd_a` passes unchanged.
- R8: Code 7 (unsigned width limit) returns 0 with an event when `opnd_a` is negative. It returns 2^s-1 with an event when `opnd_a` is above 2^s-1. Otherwise it passes `opnd_a`.
- R9: Codes 8 and 9 apply R7 and R8 respectively to each sign-extended 16-bit half of `opnd_a` separately. The lower half's result, truncated to 16 bits, goes to bits 15:0, and the upper half's goes to bits 31:16. An event in either half is an event.
- R10: A saturation event while `op_valid` is high sets `sticky_flag` on the next rising clock edge. An event while `op_valid` is low leaves the flag unchanged. The result does not depend on `op_valid`.
- R11: `sticky_flag` is 0 after reset and lowers only when `flag_clr` is high at a clock edge. If a set and a clear occur on the same edge, the flag ends up set.
- R12: Codes 10 to 15 return 0 and never raise an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_width | input | 5 | Width parameter s for the width-limit operations |
| op_valid | input | 1 | Operation strobe; qualifies flag updates |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Combinational result |
| sticky_flag | output | 1 | Sticky saturation flag |

## Verification
The exact range edges are the hardest cases to reach, because uniformly random 32-bit operands almost never hit them. These include doubling at exactly 0xC0000000, where the clamped value equals the shifted value but the event must still fire. They also include width limits where the input sits one step inside or outside 2^s-1, and one lane of a halfword pair that saturates while the other does not. The stimulus draws operands from a pool biased toward the range extremes and the powers of two near them, and it adds directed cases for each edge. A separate directed sequence lands a clear and an event on the same edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
   typedef enum logic [3:0] {
      OP_SADD     = 4'd0,
      OP_SSUB     = 4'd1,
      OP_SADD_CHK = 4'd2,
      OP_SDBL     = 4'd3,
      OP_UADD     = 4'd4,
      OP_USUB     = 4'd5,
      OP_SLIM     = 4'd6,
      OP_ULIM     = 4'd7,
      OP_SLIM2    = 4'd8,
      OP_ULIM2    = 4'd9
   } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
   import sat_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  sat_op_e            op,
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   output logic [DATA_W-1:0]  res,
   output logic               evt
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] SMAX   = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] SMIN   = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] DBL_HI = {2'b01, {(DATA_W-2){1'b0}}};
   localparam logic [DATA_W-1:0] DBL_LO = {2'b11, {(DATA_W-2){1'b0}}};

   logic [DATA_W:0]   usum, udiff;
   logic [DATA_W-1:0] sum, diff, clamp;
   logic              ovf_add, ovf_sub, dbl_hi, dbl_lo;

   always_comb begin
      usum    = {1'b0, a} + {1'b0, b};
      udiff   = {1'b0, a} - {1'b0, b};
      sum     = usum[MSB:0];
      diff    = udiff[MSB:0];
      ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      ovf_sub = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      clamp   = a[MSB] ? SMIN : SMAX;
      dbl_hi  = $signed(a) >= $signed(DBL_HI);
      dbl_lo  = $signed(a) <= $signed(DBL_LO);
      res     = '0;
      evt     = 1'b0;
      unique case (op)
         OP_SADD:     begin res = ovf_add ? clamp : sum;  evt = ovf_add; end
         OP_SSUB:     begin res = ovf_sub ? clamp : diff; evt = ovf_sub; end
         OP_SADD_CHK: begin res = sum;                    evt = ovf_add; end
         OP_SDBL: begin
            evt = dbl_hi | dbl_lo;
            res = dbl_hi ? SMAX : (dbl_lo ? SMIN : {a[MSB-1:0], 1'b0});
         end
         OP_UADD: begin res = usum[DATA_W]  ? '1 : sum;  evt = usum[DATA_W];  end
         OP_USUB: begin res = udiff[DATA_W] ? '0 : diff; evt = udiff[DATA_W]; end
         default: ;
      endcase
   end
endmodule

// File: rtl/sat_limit.sv
module sat_limit #(
   parameter int DATA_W = 32,
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val,
   input  logic [SH_W-1:0]   sh,
   input  logic              is_uns,
   output logic [DATA_W-1:0] res,
   output logic              evt
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] top;
   logic              s_hi, s_lo, u_neg, u_big;

   always_comb begin
      mask  = (DATA_W'(1) << sh) - DATA_W'(1);
      top   = $signed(val) >>> sh;
      s_hi  = !top[MSB] && (top != '0);
      s_lo  = top[MSB] && !(&top);
      u_neg = val[MSB];
      u_big = !val[MSB] && (val > mask);
      if (is_uns) begin
         evt = u_neg | u_big;
         res = u_neg ? '0 : (u_big ? mask : val);
      end else begin
         evt = s_hi | s_lo;
         res = s_hi ? mask : (s_lo ? ~mask : val);
      end
   end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= set_req | (flag & ~clr_req);
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag); // R10
   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag); // R11
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_req) |=> !flag); // R11
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(set_req)); // R10
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_LANES = 2,
   parameter int SH_W      = $clog2(DATA_W),
   parameter int OP_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [SH_W-1:0]   sat_width,
   input  logic              op_valid,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] result,
   output logic              sticky_flag
);
   localparam int LANE_W = DATA_W / NUM_LANES;

   if (DATA_W < 8 || (DATA_W % NUM_LANES) != 0) begin : g_bad_width
      $error("sat_alu: DATA_W must be at least 8 and divisible by NUM_LANES");
   end
   if (OP_W != 4) begin : g_bad_op
      $error("sat_alu: OP_W must be 4");
   end

   sat_op_e op;
   assign op = sat_op_e'(op_sel);

   logic [DATA_W-1:0] as_res, full_res;
   logic              as_evt, full_evt;
   logic              lanes_uns;

   sat_addsub #(.DATA_W(DATA_W)) u_addsub (
      .op(op), .a(opnd_a), .b(opnd_b), .res(as_res), .evt(as_evt));

   sat_limit #(.DATA_W(DATA_W), .SH_W(SH_W)) u_full (
      .val(opnd_a), .sh(sat_width), .is_uns(op == OP_ULIM),
      .res(full_res), .evt(full_evt));

   assign lanes_uns = (op == OP_ULIM2);

   logic [DATA_W-1:0]    lane_res;
   logic [NUM_LANES-1:0] lane_evt;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic [LANE_W-1:0] half;
      logic [DATA_W-1:0] ext, lim;
      assign half = opnd_a[i*LANE_W +: LANE_W];
      assign ext  = {{(DATA_W-LANE_W){half[LANE_W-1]}}, half};
      sat_limit #(.DATA_W(DATA_W), .SH_W(SH_W)) u_lim (
         .val(ext), .sh(sat_width), .is_uns(lanes_uns),
         .res(lim), .evt(lane_evt[i]));
      assign lane_res[i*LANE_W +: LANE_W] = lim[LANE_W-1:0];
   end

   logic any_evt;

   always_comb begin
      result  = '0;
      any_evt = 1'b0;
      case (op)
         OP_SADD, OP_SSUB, OP_SADD_CHK, OP_SDBL, OP_UADD, OP_USUB: begin
            result = as_res; any_evt = as_evt;
         end
         OP_SLIM, OP_ULIM:   begin result = full_res; any_evt = full_evt;  end
         OP_SLIM2, OP_ULIM2: begin result = lane_res; any_evt = |lane_evt; end
         default: ;
      endcase
   end

   sat_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set_req(op_valid & any_evt),
      .clr_req(flag_clr), .flag(sticky_flag));

   AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_W'(5) && opnd_a < opnd_b) |-> result == '0); // R6
   AST_UADD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_W'(4) && opnd_a > ~opnd_b) |-> &result); // R5
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_W'(9)) |-> result == '0); // R12
   AST_SPARE_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_W'(9) && !sticky_flag) |=> !sticky_flag); // R12
endmodule

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic [4:0]  sat_width = '0;
   logic        op_valid = 1'b0, flag_clr = 1'b0;
   logic [31:0] result;
   logic        sticky_flag;

   int checks = 0;
   int fails  = 0;
   bit exp_flag = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sat_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .sat_width(sat_width), .op_valid(op_valid),
      .flag_clr(flag_clr), .result(result), .sticky_flag(sticky_flag));

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
         4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
         4'd6: return "R7";  4'd7: return "R8";
         4'd8, 4'd9: return "R9";
         default: return "R12";
      endcase
   endfunction

   function automatic logic [32:0] lim(input longint v, input logic [4:0] s, input bit uns);
      longint hi, lo, r;
      bit e;
      hi = (longint'(1) << s) - 1;
      lo = -(longint'(1) << s);
      e = 1'b0; r = v;
      if (uns) begin
         if (v < 0) begin r = 0; e = 1'b1; end
         else if (v > hi) begin r = hi; e = 1'b1; end
      end else begin
         if (v > hi) begin r = hi; e = 1'b1; end
         else if (v < lo) begin r = lo; e = 1'b1; end
      end
      return {e, r[31:0]};
   endfunction

   function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] s);
      longint sa, sb, t, ua, ub;
      logic [32:0] lo_l, hi_l;
      sa = $signed(a); sb = $signed(b);
      ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
      case (op)
         4'd0, 4'd2: begin
            t = sa + sb;
            if (t > 64'sd2147483647)  return {1'b1, (op == 4'd0) ? 32'h7FFFFFFF : a + b};
            if (t < -64'sd2147483648) return {1'b1, (op == 4'd0) ? 32'h80000000 : a + b};
            return {1'b0, a + b};
         end
         4'd1: begin
            t = sa - sb;
            if (t > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
            if (t < -64'sd2147483648) return {1'b1, 32'h80000000};
            return {1'b0, a - b};
         end
         4'd3: begin
            if (sa >= 64'sd1073741824)  return {1'b1, 32'h7FFFFFFF};
            if (sa <= -64'sd1073741824) return {1'b1, 32'h80000000};
            return {1'b0, a << 1};
         end
         4'd4: return (ua + ub > 64'hFFFFFFFF) ? {1'b1, 32'hFFFFFFFF} : {1'b0, a + b};
         4'd5: return (ub > ua) ? {1'b1, 32'h0} : {1'b0, a - b};
         4'd6: return lim(sa, s, 1'b0);
         4'd7: return lim(sa, s, 1'b1);
         4'd8, 4'd9: begin
            lo_l = lim(longint'($signed(a[15:0])), s, op == 4'd9);
            hi_l = lim(longint'($signed(a[31:16])), s, op == 4'd9);
            return {lo_l[32] | hi_l[32], hi_l[15:0], lo_l[15:0]};
         end
         default: return 33'h0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, input bit v, input bit c);
      logic [32:0] m;
      op_sel = op; opnd_a = a; opnd_b = b; sat_width = s; op_valid = v; flag_clr = c;
      m = model(op, a, b, s);
      #2;
      check(result === m[31:0], req_of(op), "result", result, m[31:0]);
      @(posedge clk);
      exp_flag = (v && m[32]) || (exp_flag && !c);
      @(negedge clk);
      check(sticky_flag === exp_flag, (v && m[32]) ? "R10" : "R11", "flag",
            {31'b0, sticky_flag}, {31'b0, exp_flag});
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 11))
         0: return 32'h7FFFFFFF;  1: return 32'h80000000;
         2: return 32'h40000000;  3: return 32'hC0000000;
         4: return 32'hFFFFFFFF;  5: return 32'h0;
         6: return 32'h3FFFFFFF;  7: return 32'h00007FFF;
         8: return 32'hFFFF8000;  9: return 32'h1 << $urandom_range(0, 31);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(sticky_flag === 1'b0, "R11", "flag in reset", {31'b0, sticky_flag}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sticky_flag === 1'b0, "R11", "flag after reset", {31'b0, sticky_flag}, 32'h0);

      // R1 / R2 / R3 edges
      step(4'd0, 32'h7FFFFFFF, 32'h1, 0, 1, 0);
      step(4'd0, 32'h80000000, 32'hFFFFFFFF, 0, 0, 1);
      step(4'd0, 32'h7FFFFFFE, 32'h1, 0, 1, 0);
      step(4'd1, 32'h80000000, 32'h1, 0, 1, 1);
      step(4'd1, 32'h0, 32'h80000000, 0, 1, 1);
      step(4'd2, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1, 1);
      // R4 boundaries, including the exact lower edge
      step(4'd3, 32'hC0000000, 0, 0, 1, 1);
      step(4'd3, 32'hC0000001, 0, 0, 1, 1);
      step(4'd3, 32'h40000000, 0, 0, 1, 1);
      step(4'd3, 32'h3FFFFFFF, 0, 0, 1, 1);
      // R5 / R6
      step(4'd4, 32'hFFFFFFFF, 32'h1, 0, 1, 1);
      step(4'd4, 32'hFFFFFFFE, 32'h1, 0, 1, 1);
      step(4'd5, 32'h5, 32'h6, 0, 1, 1);
      step(4'd5, 32'h6, 32'h6, 0, 1, 1);
      // R7 / R8 width edges
      step(4'd6, 32'd127, 0, 5'd7, 1, 1);
      step(4'd6, 32'd128, 0, 5'd7, 1, 1);
      step(4'd6, 32'hFFFFFF80, 0, 5'd7, 1, 1);
      step(4'd6, 32'hFFFFFF7F, 0, 5'd7, 1, 1);
      step(4'd7, 32'd255, 0, 5'd8, 1, 1);
      step(4'd7, 32'd256, 0, 5'd8, 1, 1);
      step(4'd7, 32'hFFFFFFFF, 0, 5'd8, 1, 1);
      step(4'd7, 32'h12345678, 0, 5'd0, 1, 1);
      // R9 lanes: one half saturating, the other not
      step(4'd8, 32'h7FFF0010, 0, 5'd7, 1, 1);
      step(4'd8, 32'h00108000, 0, 5'd7, 1, 1);
      step(4'd9, 32'h8000_0300, 0, 5'd8, 1, 1);
      step(4'd9, 32'h0010_0020, 0, 5'd8, 1, 1);
      // R10 event without valid; R11 clear vs set on same edge
      step(4'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 1);
      step(4'd4, 32'hFFFFFFFF, 32'h2, 0, 1, 0);
      step(4'd4, 32'hFFFFFFFF, 32'h2, 0, 1, 1);
      step(4'd0, 32'h1, 32'h1, 0, 1, 0);
      step(4'd0, 32'h1, 32'h1, 0, 0, 1);
      // R12 spare codes
      step(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 1, 0);
      step(4'd15, 32'h80000000, 32'h7FFFFFFF, 5'd0, 1, 0);

      for (int i = 0; i < 1500; i++) begin
         step(4'($urandom_range(0, 11)), pick(), pick(), 5'($urandom),
              ($urandom_range(0, 3) != 0), ($urandom_range(0, 5) == 0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule